// File: doc/BRIEF.md
# Descriptor Ring Pointer Bank

This block keeps the control state of four circular descriptor rings that an Ethernet DMA engine shares with software. It holds a base address, a depth, a producer index and a consumer index for each ring. Software reaches this state through a simple 32-bit register port. The DMA side sees a per-ring step strobe, empty and full flags, a sticky error flag and the address of the descriptor it should handle next. Descriptors are 32 bytes, so pointers appear to software as byte offsets whose index sits above bit 5.

Rings 0 and 2 carry receive buffers offered to hardware and frames queued for transmit. On these rings software produces and hardware consumes. Rings 1 and 3 carry received frames and completed transmit descriptors. On these rings hardware produces and software consumes. Each side can write only the pointer it owns. The DMA step strobes are plain pulses with no back-pressure: hardware must look at the empty or full flag before it steps. A step that the ring cannot take is dropped and recorded. Base and depth are protected by unlock bits, so a stray write cannot move a ring that is in use.

Top module: `desc_ring_bank`

## Requirements
- R1: After reset, every pointer, depth, base and unlock field reads 0, the engine gate is off, and every ring reports both empty and full.
- R2: The ring groups start at byte addresses 0x500, 0x520, 0x580 and 0x5A0 for rings 0 to 3. The base address register is at +0x00 and the unlock register at +0x18. A base write takes effect only while unlock bit 2 is set, and a depth write only while unlock bit 1 is set. The unlock register reads back bits 2 and 1.
- R3: The depth register at +0x04 holds the descriptor count shifted left by 3, and reads back in the same form.
- R4: The producer pointer is at +0x08 and the consumer pointer at +0x0C. Both are byte offsets: the index is the value shifted right by 5, and bits 4:0 read back as 0.
- R5: On rings 0 and 2, software writes the producer pointer and a DMA step advances the consumer pointer. On rings 1 and 3, a DMA step advances the producer pointer and software writes the consumer pointer. A software write to a pointer that hardware owns leaves that pointer unchanged.
- R6: A pointer advanced by a DMA step wraps to index 0 when the next index reaches the depth.
- R7: A ring is empty when both indices are equal. It is full when the producer's next index equals the consumer index, so it holds at most depth minus one entries. A ring with a depth below 2 reports both flags.
- R8: A step into a full ring (rings 1, 3) or out of an empty ring (rings 0, 2) leaves the pointer unchanged and sets that ring's error flag. The flag stays set until reset.
- R9: The gate register at 0x5CC stores bits 3:0. The DMA engines run only while all four bits are set. While they do not run, steps are dropped and no error is flagged.
- R10: Each ring's descriptor address output equals its base plus 32 times the index of the pointer that hardware owns. Addresses outside the map read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| hw_step | input | 4 | Per-ring DMA produce/consume pulse |
| ring_empty | output | 4 | Per-ring empty flag |
| ring_full | output | 4 | Per-ring full flag |
| ring_err | output | 4 | Per-ring sticky overflow/underflow flag |
| desc_addr | output | 128 | Per-ring next-descriptor address, ring i at bits 32*i+31:32*i |
| engines_on | output | 1 | All four gate bits set |

## Verification
Ring 0 is filled by software to capacity and then drained by DMA steps, one past empty, which shows the difference between a taken step and a dropped one. Ring 1 is filled by DMA steps to one past full, then freed by a software consumer write. This exercises the mirrored ownership and the wrap from the last index back to 0. Ring 2 is stepped with the gate partly set, which separates a step that the gate blocks from an underflow. Ring 3 receives base and depth writes under each unlock pattern, which shows that each field obeys only its own unlock bit.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
  localparam int NRING = 4;
  localparam logic [11:0] GATE_ADDR = 12'h5CC;
  localparam logic [4:0] OFS_BASE  = 5'h00;
  localparam logic [4:0] OFS_DEPTH = 5'h04;
  localparam logic [4:0] OFS_PROD  = 5'h08;
  localparam logic [4:0] OFS_CONS  = 5'h0C;
  localparam logic [4:0] OFS_LOCK  = 5'h18;

  function automatic logic [11:0] group_addr(input int i);
    case (i)
      0:       return 12'h500;
      1:       return 12'h520;
      2:       return 12'h580;
      default: return 12'h5A0;
    endcase
  endfunction

  function automatic bit hw_is_consumer(input int i);
    return (i == 0) || (i == 2);
  endfunction
endpackage

// File: rtl/ring_wrap_inc.sv
module ring_wrap_inc #(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] depth,
  output logic [IDX_W-1:0] nxt
);
  logic [IDX_W:0] sum;
  always_comb begin
    sum = {1'b0, idx} + {{IDX_W{1'b0}}, 1'b1};
    if (sum >= {1'b0, depth}) nxt = '0;
    else                      nxt = sum[IDX_W-1:0];
  end
endmodule

// File: rtl/ring_ctx.sv
module ring_ctx #(
  parameter int IDX_W = 8,
  parameter bit HW_CONSUMES = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic             depth_we,
  input  logic             prod_we,
  input  logic             cons_we,
  input  logic             lock_we,
  input  logic [31:0]      wdata,
  input  logic             step,
  input  logic             step_en,
  output logic [31:0]      base,
  output logic [IDX_W-1:0] depth,
  output logic [IDX_W-1:0] prod_idx,
  output logic [IDX_W-1:0] cons_idx,
  output logic [1:0]       lock,
  output logic             empty,
  output logic             full,
  output logic             err,
  output logic [31:0]      dma_addr
);
  logic [31:0]      base_q;
  logic [IDX_W-1:0] depth_q, prod_q, cons_q, hw_idx, hw_nxt, prod_nxt;
  logic [1:0]       lock_q;
  logic             err_q, take, reject, blocked;

  assign hw_idx = HW_CONSUMES ? cons_q : prod_q;

  ring_wrap_inc #(.IDX_W(IDX_W)) u_hw_inc (.idx(hw_idx), .depth(depth_q), .nxt(hw_nxt));
  ring_wrap_inc #(.IDX_W(IDX_W)) u_prod_inc (.idx(prod_q), .depth(depth_q), .nxt(prod_nxt));

  always_comb begin
    empty   = (prod_q == cons_q) || (depth_q < IDX_W'(2));
    full    = (prod_nxt == cons_q) || (depth_q < IDX_W'(2));
    blocked = HW_CONSUMES ? empty : full;
    take    = step && step_en && !blocked;
    reject  = step && step_en && blocked;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      depth_q <= '0;
      prod_q  <= '0;
      cons_q  <= '0;
      lock_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      if (lock_we) lock_q <= {wdata[2], wdata[1]};
      if (base_we && lock_q[1]) base_q <= wdata;
      if (depth_we && lock_q[0]) depth_q <= wdata[IDX_W+2:3];
      if (HW_CONSUMES) begin
        if (prod_we) prod_q <= wdata[IDX_W+4:5];
        if (take)    cons_q <= hw_nxt;
      end else begin
        if (cons_we) cons_q <= wdata[IDX_W+4:5];
        if (take)    prod_q <= hw_nxt;
      end
      if (reject) err_q <= 1'b1;
    end
  end

  assign base     = base_q;
  assign depth    = depth_q;
  assign prod_idx = prod_q;
  assign cons_idx = cons_q;
  assign lock     = lock_q;
  assign err      = err_q;
  assign dma_addr = base_q + {{(32-IDX_W-5){1'b0}}, hw_idx, 5'b0};

  // R2
  base_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q[1] |=> $stable(base_q));
  // R2
  depth_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q[0] |=> $stable(depth_q));
  // R8
  bad_step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> $stable(hw_idx));
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R7
  both_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && full) |-> (depth_q < IDX_W'(2)));
  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ({1'b0, hw_idx} + 1'b1 == {1'b0, depth_q})) |=> (hw_idx == '0));
endmodule

// File: rtl/desc_ring_bank.sv
module desc_ring_bank
  import desc_ring_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [11:0]  reg_addr,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  input  logic [3:0]   hw_step,
  output logic [3:0]   ring_empty,
  output logic [3:0]   ring_full,
  output logic [3:0]   ring_err,
  output logic [127:0] desc_addr,
  output logic         engines_on
);
  localparam int GATE_W = 4;

  logic [GATE_W-1:0] gate_q;
  logic [NRING-1:0]  hit;
  logic [4:0]        ofs;
  logic [31:0]       base_a [NRING];
  logic [IDX_W-1:0]  depth_a [NRING];
  logic [IDX_W-1:0]  prod_a [NRING];
  logic [IDX_W-1:0]  cons_a [NRING];
  logic [1:0]        lock_a [NRING];

  assign ofs = reg_addr[4:0];
  assign engines_on = &gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= '0;
    else if (reg_wr && reg_addr == GATE_ADDR) gate_q <= reg_wdata[GATE_W-1:0];
  end

  for (genvar i = 0; i < NRING; i++) begin : g_ring
    localparam logic [11:0] GA = group_addr(i);
    assign hit[i] = (reg_addr[11:5] == GA[11:5]);

    ring_ctx #(.IDX_W(IDX_W), .HW_CONSUMES(hw_is_consumer(i))) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .base_we  (reg_wr && hit[i] && ofs == OFS_BASE),
      .depth_we (reg_wr && hit[i] && ofs == OFS_DEPTH),
      .prod_we  (reg_wr && hit[i] && ofs == OFS_PROD),
      .cons_we  (reg_wr && hit[i] && ofs == OFS_CONS),
      .lock_we  (reg_wr && hit[i] && ofs == OFS_LOCK),
      .wdata    (reg_wdata),
      .step     (hw_step[i]),
      .step_en  (engines_on),
      .base     (base_a[i]),
      .depth    (depth_a[i]),
      .prod_idx (prod_a[i]),
      .cons_idx (cons_a[i]),
      .lock     (lock_a[i]),
      .empty    (ring_empty[i]),
      .full     (ring_full[i]),
      .err      (ring_err[i]),
      .dma_addr (desc_addr[i*32 +: 32])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NRING; i++) begin
      if (hit[i]) begin
        case (ofs)
          OFS_BASE:  reg_rdata = base_a[i];
          OFS_DEPTH: reg_rdata = 32'(depth_a[i]) << 3;
          OFS_PROD:  reg_rdata = 32'(prod_a[i]) << 5;
          OFS_CONS:  reg_rdata = 32'(cons_a[i]) << 5;
          OFS_LOCK:  reg_rdata = {29'b0, lock_a[i], 1'b0};
          default:   reg_rdata = '0;
        endcase
      end
    end
    if (reg_addr == GATE_ADDR) reg_rdata = {28'b0, gate_q};
  end

  // R9
  gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !engines_on |=> $stable(ring_err));
endmodule

// File: tb/desc_ring_bank_test.sv
module desc_ring_bank_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [11:0]  reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [3:0]   hw_step = '0;
  logic [3:0]   ring_empty, ring_full, ring_err;
  logic [127:0] desc_addr;
  logic         engines_on;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  desc_ring_bank uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_step(hw_step),
    .ring_empty(ring_empty), .ring_full(ring_full), .ring_err(ring_err),
    .desc_addr(desc_addr), .engines_on(engines_on)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic step(input logic [3:0] m);
    @(negedge clk);
    hw_step = m;
    @(negedge clk);
    hw_step = '0;
  endtask

  task automatic t_reset;
    rd("R1 ring0 prod", 12'h508, 0);
    rd("R1 ring1 cons", 12'h52C, 0);
    rd("R1 ring2 depth", 12'h584, 0);
    rd("R1 gate", 12'h5CC, 0);
    chk("R1 empty", 32'(ring_empty), 32'hF);
    chk("R1 full", 32'(ring_full), 32'hF);
    chk("R1 engines_on", 32'(engines_on), 0);
  endtask

  task automatic t_unlock;
    wr(12'h5A0, 32'h55);
    rd("R2 base locked", 12'h5A0, 0);
    wr(12'h5B8, 32'h4);
    rd("R2 unlock readback", 12'h5B8, 32'h4);
    wr(12'h5A0, 32'h3000_0040);
    wr(12'h5A4, 32'd40);
    rd("R2 base unlocked", 12'h5A0, 32'h3000_0040);
    rd("R2 depth still locked", 12'h5A4, 0);
    wr(12'h5B8, 32'h2);
    wr(12'h5A4, 32'd40);
    wr(12'h5A0, 32'h1);
    rd("R3 depth count<<3", 12'h5A4, 32'd40);
    rd("R2 base relocked", 12'h5A0, 32'h3000_0040);
    chk("R10 ring3 addr", desc_addr[127:96], 32'h3000_0040);
    rd("R10 unmapped", 12'h600, 0);
  endtask

  task automatic t_ring0;
    wr(12'h518, 32'h6);
    wr(12'h500, 32'h1000_0000);
    wr(12'h504, 32'd32);
    wr(12'h518, 32'h0);
    wr(12'h5CC, 32'hF);
    chk("R9 engines on", 32'(engines_on), 1);
    wr(12'h508, 32'd96);
    rd("R4 prod offset", 12'h508, 32'd96);
    chk("R7 ring0 full", 32'(ring_full[0]), 1);
    chk("R7 ring0 not empty", 32'(ring_empty[0]), 0);
    chk("R10 ring0 addr", desc_addr[31:0], 32'h1000_0000);
    step(4'h1);
    rd("R5 hw consumes", 12'h50C, 32'd32);
    chk("R10 ring0 addr step", desc_addr[31:0], 32'h1000_0020);
    chk("R7 ring0 not full", 32'(ring_full[0]), 0);
    step(4'h1);
    step(4'h1);
    chk("R7 ring0 empty", 32'(ring_empty[0]), 1);
    chk("R8 no err yet", 32'(ring_err[0]), 0);
    step(4'h1);
    chk("R8 underflow err", 32'(ring_err[0]), 1);
    rd("R8 cons held", 12'h50C, 32'd96);
    wr(12'h50C, 32'd0);
    rd("R5 sw cons write ignored", 12'h50C, 32'd96);
    wr(12'h508, 32'd0);
    step(4'h1);
    rd("R6 cons wrap", 12'h50C, 32'd0);
    chk("R8 err sticky", 32'(ring_err[0]), 1);
  endtask

  task automatic t_ring1;
    wr(12'h538, 32'h6);
    wr(12'h520, 32'h0000_2000);
    wr(12'h524, 32'd24);
    wr(12'h538, 32'h0);
    step(4'h2);
    step(4'h2);
    rd("R5 hw produces", 12'h528, 32'd64);
    chk("R7 ring1 full", 32'(ring_full[1]), 1);
    chk("R10 ring1 addr", desc_addr[63:32], 32'h0000_2040);
    step(4'h2);
    chk("R8 overflow err", 32'(ring_err[1]), 1);
    rd("R8 prod held", 12'h528, 32'd64);
    wr(12'h528, 32'd0);
    rd("R5 sw prod write ignored", 12'h528, 32'd64);
    wr(12'h52C, 32'd33);
    rd("R4 low bits zero", 12'h52C, 32'd32);
    chk("R7 ring1 room", 32'(ring_full[1]), 0);
    step(4'h2);
    rd("R6 prod wrap", 12'h528, 32'd0);
  endtask

  task automatic t_gate;
    wr(12'h598, 32'h2);
    wr(12'h584, 32'd32);
    wr(12'h598, 32'h0);
    wr(12'h588, 32'd32);
    wr(12'h5CC, 32'h7);
    chk("R9 partial gate off", 32'(engines_on), 0);
    rd("R9 gate readback", 12'h5CC, 32'h7);
    step(4'h4);
    rd("R9 step dropped", 12'h58C, 0);
    wr(12'h5CC, 32'h0);
    step(4'h8);
    chk("R9 no err while off", 32'(ring_err[3]), 0);
    wr(12'h5CC, 32'hF);
    step(4'h4);
    rd("R9 step taken", 12'h58C, 32'd32);
    chk("R7 ring2 empty", 32'(ring_empty[2]), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unlock();
    t_ring0();
    t_ring1();
    t_gate();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule